// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells the front end of an out-of-order core which in-flight store a newly fetched load or store must wait for before it may issue. It learns "store sets" from memory-ordering violations. A store set is the group of stores that have collided with a given load in the past. A set table, indexed by instruction address, gives each memory instruction an optional set number. A last-store table, indexed by set number, holds the tag of the most recently fetched store of each set that has not yet completed.

At fetch the block looks up the instruction's set and reports, in the same cycle, the tag it has to wait on. A fetched store also records itself as the newest store of its set, which chains the stores of a set behind one another. When a violation is reported, the load and the store join a common set, and two existing sets are unified onto the smaller number. Completing stores retire their entries. A periodic clear forgets every learned set.

Top module: `ssp_predictor`

## Requirements
- R1: While reset is high and immediately after it, no set is known and every fetch reports no wait.
- R2: `fetch_wait_valid` and `fetch_wait_tag` are zero whenever `fetch_valid` is low or the fetched address has no set.
- R3: A fetched load whose address has a set reports, in the same cycle, the tag of the newest in-flight store recorded for that set, with `fetch_wait_valid` high. If no store of that set is in flight, it reports no wait.
- R4: A fetched store whose address has a set reports the previous in-flight store of that set in the same way. From the next cycle on, it is itself the newest store of that set.
- R5: A violation in which neither address has a set gives both the set number formed by address bits [8:2] of the load.
- R6: A violation in which only one of the two addresses has a set places the other address in that set.
- R7: A violation in which both addresses have sets gives both the numerically smaller set number.
- R8: A store completion removes a last-store entry only if that entry still holds the completing tag. It takes effect from the next cycle.
- R9: A clear pulse empties the set table from the next cycle on. In the same cycle it overrides a violation report.
- R10: When a store is fetched in the same cycle as a completion that matches its set's entry, the newly fetched store is what the entry holds afterwards.
- R11: The set table is indexed by address bits [11:2]. Addresses that agree in those bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A memory instruction is fetched this cycle |
| fetch_pc | input | 32 | Instruction address of the fetched instruction |
| fetch_is_store | input | 1 | 1 for a store, 0 for a load |
| fetch_tag | input | 6 | In-flight tag of the fetched instruction |
| fetch_wait_valid | output | 1 | The fetched instruction must wait |
| fetch_wait_tag | output | 6 | Tag of the store to wait for |
| done_valid | input | 1 | A store has completed |
| done_tag | input | 6 | Tag of the completed store |
| viol_valid | input | 1 | A load/store ordering violation is reported |
| viol_load_pc | input | 32 | Address of the violating load |
| viol_store_pc | input | 32 | Address of the offending store |
| clear_pulse | input | 1 | Forget all learned sets |

## Verification
The assertions assume that no two in-flight stores carry the same tag and that a completion names only a store that was fetched and has not yet completed. The bench allocates store tags from a range disjoint from any tag still outstanding. It completes only tags held in its outstanding list, and it caps the number outstanding so that a free tag always exists. Violations and clears are drawn freely, because the predictor must accept any pairing of addresses.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    parameter int PC_W   = 32;
    parameter int IDX_W  = 10;
    parameter int SSID_W = 7;
    parameter int TAG_W  = 6;

    localparam int SET_DEPTH  = 1 << IDX_W;
    localparam int LAST_DEPTH = 1 << SSID_W;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [SSID_W-1:0] ssid_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  valid;
        ssid_t id;
    } set_ent_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } last_ent_t;

    typedef enum logic [1:0] {
        MG_FRESH,
        MG_TO_LOAD,
        MG_TO_STORE,
        MG_UNIFY
    } merge_e;

    function automatic idx_t pc_index(input pc_t pc);
        return pc[IDX_W+1:2];
    endfunction

    function automatic ssid_t pc_seed(input pc_t pc);
        return pc[SSID_W+1:2];
    endfunction
endpackage

// File: rtl/ssp_set_table.sv
module ssp_set_table
    import ssp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  idx_t     rd_a_idx,
    output set_ent_t rd_a,
    input  idx_t     rd_b_idx,
    output set_ent_t rd_b,
    input  idx_t     rd_c_idx,
    output set_ent_t rd_c,
    input  logic     wr_en,
    input  idx_t     wr0_idx,
    input  idx_t     wr1_idx,
    input  ssid_t    wr_id
);
    logic [SET_DEPTH-1:0] vld;
    ssid_t                ids [SET_DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr0_idx] <= 1'b1;
            vld[wr1_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            ids[wr0_idx] <= wr_id;
            ids[wr1_idx] <= wr_id;
        end
    end

    assign rd_a = '{valid: vld[rd_a_idx], id: ids[rd_a_idx]};
    assign rd_b = '{valid: vld[rd_b_idx], id: ids[rd_b_idx]};
    assign rd_c = '{valid: vld[rd_c_idx], id: ids[rd_c_idx]};
endmodule

// File: rtl/ssp_last_table.sv
module ssp_last_table
    import ssp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ssid_t     rd_id,
    output last_ent_t rd_ent,
    input  logic      wr_en,
    input  ssid_t     wr_id,
    input  tag_t      wr_tag,
    input  logic      done_en,
    input  tag_t      done_tag
);
    logic [LAST_DEPTH-1:0] vld;
    tag_t                  tags [LAST_DEPTH];
    logic [LAST_DEPTH-1:0] retire;

    for (genvar g = 0; g < LAST_DEPTH; g++) begin : g_match
        assign retire[g] = done_en && vld[g] && (tags[g] == done_tag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            vld <= vld & ~retire;
            if (wr_en) vld[wr_id] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tags[wr_id] <= wr_tag;
    end

    assign rd_ent = '{valid: vld[rd_id], tag: tags[rd_id]};
endmodule

// File: rtl/ssp_merge.sv
module ssp_merge
    import ssp_pkg::*;
(
    input  set_ent_t ld_ent,
    input  set_ent_t st_ent,
    input  pc_t      ld_pc,
    output ssid_t    new_id
);
    merge_e kind;

    always_comb begin
        unique case ({ld_ent.valid, st_ent.valid})
            2'b00:   kind = MG_FRESH;
            2'b01:   kind = MG_TO_STORE;
            2'b10:   kind = MG_TO_LOAD;
            default: kind = MG_UNIFY;
        endcase
    end

    always_comb begin
        unique case (kind)
            MG_FRESH:    new_id = pc_seed(ld_pc);
            MG_TO_STORE: new_id = st_ent.id;
            MG_TO_LOAD:  new_id = ld_ent.id;
            default:     new_id = (ld_ent.id < st_ent.id) ? ld_ent.id : st_ent.id;
        endcase
    end
endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
    import ssp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fetch_valid,
    input  logic [ssp_pkg::PC_W-1:0]  fetch_pc,
    input  logic                   fetch_is_store,
    input  logic [ssp_pkg::TAG_W-1:0] fetch_tag,
    output logic                   fetch_wait_valid,
    output logic [ssp_pkg::TAG_W-1:0] fetch_wait_tag,
    input  logic                   done_valid,
    input  logic [ssp_pkg::TAG_W-1:0] done_tag,
    input  logic                   viol_valid,
    input  logic [ssp_pkg::PC_W-1:0]  viol_load_pc,
    input  logic [ssp_pkg::PC_W-1:0]  viol_store_pc,
    input  logic                   clear_pulse
);
    set_ent_t  fetch_set, vl_set, vs_set;
    last_ent_t last_ent;
    ssid_t     merged_id;
    logic      fetch_hit;

    ssp_set_table u_sets (
        .clk      (clk),
        .rst      (rst),
        .clr      (clear_pulse),
        .rd_a_idx (pc_index(fetch_pc)),
        .rd_a     (fetch_set),
        .rd_b_idx (pc_index(viol_load_pc)),
        .rd_b     (vl_set),
        .rd_c_idx (pc_index(viol_store_pc)),
        .rd_c     (vs_set),
        .wr_en    (viol_valid),
        .wr0_idx  (pc_index(viol_load_pc)),
        .wr1_idx  (pc_index(viol_store_pc)),
        .wr_id    (merged_id)
    );

    ssp_merge u_merge (
        .ld_ent (vl_set),
        .st_ent (vs_set),
        .ld_pc  (viol_load_pc),
        .new_id (merged_id)
    );

    assign fetch_hit = fetch_valid && fetch_set.valid;

    ssp_last_table u_last (
        .clk      (clk),
        .rst      (rst),
        .rd_id    (fetch_set.id),
        .rd_ent   (last_ent),
        .wr_en    (fetch_hit && fetch_is_store),
        .wr_id    (fetch_set.id),
        .wr_tag   (fetch_tag),
        .done_en  (done_valid),
        .done_tag (done_tag)
    );

    assign fetch_wait_valid = fetch_hit && last_ent.valid;
    assign fetch_wait_tag   = fetch_wait_valid ? last_ent.tag : '0;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker
    import ssp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic fetch_valid,
    input pc_t  fetch_pc,
    input logic fetch_is_store,
    input tag_t fetch_tag,
    input logic fetch_wait_valid,
    input tag_t fetch_wait_tag,
    input logic fetch_hit,
    input logic done_valid,
    input tag_t done_tag,
    input logic viol_valid,
    input pc_t  viol_load_pc,
    input pc_t  viol_store_pc,
    input logic clear_pulse
);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> (!fetch_wait_valid && fetch_wait_tag == '0));

    a_r4_store_chain: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && fetch_valid && fetch_is_store && fetch_hit && !viol_valid && !clear_pulse)
         && fetch_valid && fetch_pc == $past(fetch_pc))
        |-> (fetch_wait_valid && fetch_wait_tag == $past(fetch_tag)));

    a_r5_viol_store_joins: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && viol_valid && !clear_pulse) && fetch_valid
         && fetch_pc == $past(viol_store_pc)) |-> fetch_hit);

    a_r5_viol_load_joins: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && viol_valid && !clear_pulse) && fetch_valid
         && fetch_pc == $past(viol_load_pc)) |-> fetch_hit);

    a_r8_done_retires: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && done_valid && !fetch_valid) && fetch_valid)
        |-> !(fetch_wait_valid && fetch_wait_tag == $past(done_tag)));

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        $past(clear_pulse) |-> !fetch_hit);
endmodule

bind ssp_predictor ssp_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .fetch_valid      (fetch_valid),
    .fetch_pc         (fetch_pc),
    .fetch_is_store   (fetch_is_store),
    .fetch_tag        (fetch_tag),
    .fetch_wait_valid (fetch_wait_valid),
    .fetch_wait_tag   (fetch_wait_tag),
    .fetch_hit        (fetch_hit),
    .done_valid       (done_valid),
    .done_tag         (done_tag),
    .viol_valid       (viol_valid),
    .viol_load_pc     (viol_load_pc),
    .viol_store_pc    (viol_store_pc),
    .clear_pulse      (clear_pulse)
);

// File: tb/tb_ssp_predictor.sv
module tb_ssp_predictor;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid, fetch_is_store, done_valid, viol_valid, clear_pulse;
    logic [31:0] fetch_pc, viol_load_pc, viol_store_pc;
    logic [5:0]  fetch_tag, done_tag;
    logic        fetch_wait_valid;
    logic [5:0]  fetch_wait_tag;

    ssp_predictor dut (.*);

    always #(PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    int set_of[int];
    int last_of[int];
    int outstanding[$];

    function automatic int idx_of(logic [31:0] pc);
        return int'((pc >> 2) & 32'h3FF);
    endfunction

    task automatic quiet();
        fetch_valid = 0; fetch_is_store = 0; fetch_pc = 0; fetch_tag = 0;
        done_valid = 0; done_tag = 0; viol_valid = 0;
        viol_load_pc = 0; viol_store_pc = 0; clear_pulse = 0;
    endtask

    task automatic model_update();
        int kill[$];
        if (done_valid) begin
            foreach (last_of[k]) if (last_of[k] == int'(done_tag)) kill.push_back(k);
            foreach (kill[j]) last_of.delete(kill[j]);
        end
        if (fetch_valid && fetch_is_store && set_of.exists(idx_of(fetch_pc)))
            last_of[set_of[idx_of(fetch_pc)]] = int'(fetch_tag);
        if (clear_pulse) begin
            set_of.delete();
        end else if (viol_valid) begin
            int li = idx_of(viol_load_pc);
            int si = idx_of(viol_store_pc);
            int nid;
            if (!set_of.exists(li) && !set_of.exists(si)) nid = int'((viol_load_pc >> 2) & 32'h7F);
            else if (!set_of.exists(si)) nid = set_of[li];
            else if (!set_of.exists(li)) nid = set_of[si];
            else nid = (set_of[li] < set_of[si]) ? set_of[li] : set_of[si];
            set_of[li] = nid;
            set_of[si] = nid;
        end
    endtask

    // Drive happens after a falling edge; compare, then advance one clock.
    task automatic cyc(string req);
        bit   ev;
        int   et;
        ev = 0; et = 0;
        #1;
        if (!rst && fetch_valid && set_of.exists(idx_of(fetch_pc))
            && last_of.exists(set_of[idx_of(fetch_pc)])) begin
            ev = 1;
            et = last_of[set_of[idx_of(fetch_pc)]];
        end
        n_vec++;
        if (fetch_wait_valid !== ev || int'(fetch_wait_tag) !== et) begin
            n_bad++;
            $display("FAIL %s: wait=%0b tag=%0d expected wait=%0b tag=%0d",
                     req, fetch_wait_valid, fetch_wait_tag, ev, et);
        end
        @(posedge clk);
        if (!rst) model_update();
        @(negedge clk);
        quiet();
    endtask

    task automatic fet(logic [31:0] pc, bit st, int tg, string req);
        fetch_valid = 1; fetch_pc = pc; fetch_is_store = st; fetch_tag = 6'(tg);
        cyc(req);
    endtask

    task automatic vio(logic [31:0] lp, logic [31:0] sp);
        viol_valid = 1; viol_load_pc = lp; viol_store_pc = sp;
        cyc("R5");
    endtask

    task automatic fin();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        fin();
    end

    localparam logic [31:0] LA = 32'h014, S1 = 32'h024, LB = 32'h00C,
                            S2 = 32'h050, S3 = 32'h100, LC = 32'h200, LAX = 32'h1014;

    initial begin
        quiet();
        rst = 1;
        @(negedge clk);
        fet(LA, 0, 0, "R1");
        rst = 0;
        // R1/R2: nothing learned yet
        fet(LA, 0, 0, "R1");
        fet(S1, 1, 1, "R2");
        cyc("R2");
        // R5: fresh set from the load address
        vio(LA, S1);
        fet(S1, 1, 2, "R4");
        fet(LA, 0, 9, "R3");
        fet(S1, 1, 3, "R4");
        done_valid = 1; done_tag = 2; cyc("R8");
        fet(LA, 0, 9, "R8");
        done_valid = 1; done_tag = 3; cyc("R8");
        fet(LA, 0, 9, "R8");
        // R7: two sets unify onto the smaller number
        vio(LB, S2);
        viol_valid = 1; viol_load_pc = LA; viol_store_pc = S2; cyc("R7");
        fet(S2, 1, 4, "R7");
        fet(LB, 0, 9, "R7");
        fet(LA, 0, 9, "R7");
        // R6: one side joins the other
        viol_valid = 1; viol_load_pc = LA; viol_store_pc = S3; cyc("R6");
        fet(S3, 1, 5, "R6");
        viol_valid = 1; viol_load_pc = LC; viol_store_pc = S1; cyc("R6");
        fet(S1, 1, 6, "R6");
        fet(LC, 0, 9, "R6");
        // R10: fetch write beats same-cycle completion
        done_valid = 1; done_tag = 6; fet(S1, 1, 7, "R10");
        fet(LC, 0, 9, "R10");
        // R9: clear overrides a same-cycle violation
        clear_pulse = 1; viol_valid = 1; viol_load_pc = LB; viol_store_pc = S1; cyc("R9");
        fet(LB, 0, 9, "R9");
        fet(S1, 1, 8, "R9");
        // R11: aliasing addresses share the set entry
        vio(LA, S1);
        fet(S1, 1, 8, "R11");
        fet(LAX, 0, 9, "R11");
        for (int t = 1; t <= 8; t++) begin
            done_valid = 1; done_tag = 6'(t); cyc("R8");
        end

        // Random phase: store tags 16..63, completions only of outstanding tags
        begin
            logic [31:0] pool [12];
            int next_tag;
            next_tag = 16;
            for (int i = 0; i < 12; i++) pool[i] = 32'(((i * 37) % 24) * 4 + ((i % 3 == 0) ? 32'h1000 : 0));
            for (int n = 0; n < 3000; n++) begin
                int r;
                r = $urandom_range(0, 99);
                if (r < 55) begin
                    fetch_valid = 1;
                    fetch_pc = pool[$urandom_range(0, 11)];
                    fetch_is_store = ($urandom_range(0, 1) == 1) && (outstanding.size() < 40);
                    if (fetch_is_store) begin
                        int guard;
                        guard = 0;
                        while (next_tag inside {outstanding} && guard < 64) begin
                            next_tag = (next_tag == 63) ? 16 : next_tag + 1;
                            guard++;
                        end
                        fetch_tag = 6'(next_tag);
                        outstanding.push_back(next_tag);
                        next_tag = (next_tag == 63) ? 16 : next_tag + 1;
                    end else begin
                        fetch_tag = 6'($urandom_range(0, 63));
                    end
                end
                if ((r % 3 == 0 || outstanding.size() >= 40) && outstanding.size() > 0
                    && !(fetch_valid && fetch_is_store && outstanding.size() == 1)) begin
                    int k;
                    k = $urandom_range(0, outstanding.size() - 1);
                    if (fetch_valid && fetch_is_store && k == outstanding.size() - 1) k = 0;
                    done_valid = 1;
                    done_tag = 6'(outstanding[k]);
                    outstanding.delete(k);
                end
                if ($urandom_range(0, 9) == 0) begin
                    viol_valid = 1;
                    viol_load_pc = pool[$urandom_range(0, 11)];
                    viol_store_pc = pool[$urandom_range(0, 11)];
                end
                if ($urandom_range(0, 199) == 0) clear_pulse = 1;
                cyc(clear_pulse ? "R9" : (viol_valid ? "R7" : (done_valid ? "R8" : "R3")));
            end
        end
        fin();
    end
endmodule